// File: doc/BRIEF.md
# Byte/Word Memory Lane Steering

This block connects a 16-bit register data path to a 16-bit-wide, little-endian memory that takes byte addresses. On each request it decides which byte lanes of memory are written, and it shifts the word read back from memory so that a byte fetched from an odd address lands in the low half of the register value. Byte and word requests share one path. A word request always has address bit 0 clear. A byte request uses address bit 0 to pick the lower lane (even address) or the upper lane (odd address).

Memory read data comes back one clock after the read request. The block therefore registers the lane choice of each read request and applies it to the data that returns. Writes are steered in the same cycle as the request. The write word goes to memory as it is. Software must copy the byte into both halves before a byte store, because only the enabled lane is written. On a read, the upper byte of the result is not cleared: it always carries the memory's upper byte. Any masking of that byte is left to software.

Top module: `mem_lane_steer`

## Requirements
- R1: After reset, and until the first read request, `rd_word` equals `mem_rdata` unchanged.
- R2: For a read request (`req_valid`=1, `req_write`=0) with `addr_lsb`=0, byte or word, `rd_word` equals `mem_rdata` in the following cycle.
- R3: For a read request with `addr_lsb`=1, byte or word, in the following cycle `rd_word[7:0]` equals `mem_rdata[15:8]`, and `rd_word[15:8]` also equals `mem_rdata[15:8]`, with no zero or sign extension.
- R4: The lane choice used for read data is held from one read request to the next. Write requests and idle cycles leave it unchanged.
- R5: A byte write (`req_valid`=1, `req_write`=1, `req_byte`=1) drives `mem_be`=2'b01 (bit 0 enables bits 7:0) when `addr_lsb`=0, and 2'b10 (bit 1 enables bits 15:8) when `addr_lsb`=1, in the same cycle.
- R6: A word write (`req_byte`=0) drives `mem_be`=2'b11 in the same cycle.
- R7: When `req_valid`=0, or when the request is a read, `mem_be`=2'b00.
- R8: `mem_wdata` always equals `wr_word`, unchanged, for byte and word writes alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Memory access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| addr_lsb | input | 1 | Byte address bit 0 |
| wr_word | input | 16 | Register word to store |
| mem_rdata | input | 16 | Memory read word, valid the cycle after a read request |
| mem_be | output | 2 | Per-lane write enables, bit i for bits 8i+7:8i |
| mem_wdata | output | 16 | Word presented to memory |
| rd_word | output | 16 | Steered word returned to the register file |

## Verification
The only state in the block is the registered lane choice. If it is wrong, the low byte of `rd_word` shows the wrong memory byte on the very cycle the read data returns. If the choice is kept too long or lost too early, the error shows on the first read that follows, or after an intervening write. Write enables have no state, so a fault there is visible on `mem_be` in the same cycle as the request. The sweep covers every combination of strobe, direction, size and address bit 0 against many data words. It also places writes between reads to expose a lane choice that a write disturbs.

// File: rtl/lane_pkg.sv
package lane_pkg;

    localparam int LANE_W    = 8;
    localparam int NUM_LANES = 2;
    localparam int WORD_W    = LANE_W * NUM_LANES;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    typedef struct packed {
        logic  valid;
        logic  write;
        logic  byte_acc;
        lane_e lane;
    } req_t;

    function automatic logic lane_enabled(input req_t r, input int idx);
        logic hit;
        hit = r.byte_acc ? (int'(r.lane) == idx) : 1'b1;
        return r.valid && r.write && hit;
    endfunction

    function automatic logic is_read(input req_t r);
        return r.valid && !r.write;
    endfunction

endpackage

// File: rtl/lane_wr_enable.sv
module lane_wr_enable
    import lane_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  req_t                 req,
    output logic [NUM_LANES-1:0] be
);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign be[g] = lane_enabled(req, g);
    end

    AST_BE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(req.valid && req.write) |-> (be == '0));                          // R7

    AST_BE_BYTE_ONE: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.write && req.byte_acc) |-> ($countones(be) == 1)); // R5

    AST_BE_WORD_ALL: assert property (@(posedge clk) disable iff (rst)
        (req.valid && req.write && !req.byte_acc) |-> (&be));                // R6

endmodule

// File: rtl/lane_rd_steer.sv
module lane_rd_steer
    import lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  req_t              req,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] rd_word
);

    lane_e sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= LANE_LO;
        end else if (is_read(req)) begin
            sel_q <= req.lane;
        end
    end

    always_comb begin
        rd_word = mem_rdata;
        if (sel_q == LANE_HI) begin
            rd_word[LANE_W-1:0] = mem_rdata[WORD_W-1:WORD_W-LANE_W];
        end
    end

    AST_RD_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (rd_word[WORD_W-1:LANE_W] == mem_rdata[WORD_W-1:LANE_W])); // R3

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !is_read(req) |=> $stable(sel_q));                                  // R4

endmodule

// File: rtl/mem_lane_steer.sv
module mem_lane_steer
    import lane_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_byte,
    input  logic                 addr_lsb,
    input  logic [WORD_W-1:0]    wr_word,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic [NUM_LANES-1:0] mem_be,
    output logic [WORD_W-1:0]    mem_wdata,
    output logic [WORD_W-1:0]    rd_word
);

    req_t req;

    always_comb begin
        req.valid    = req_valid;
        req.write    = req_write;
        req.byte_acc = req_byte;
        req.lane     = lane_e'(addr_lsb);
    end

    lane_wr_enable u_wr (
        .clk (clk),
        .rst (rst),
        .req (req),
        .be  (mem_be)
    );

    lane_rd_steer u_rd (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .mem_rdata (mem_rdata),
        .rd_word   (rd_word)
    );

    assign mem_wdata = wr_word;

    AST_WDATA_PASS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (mem_wdata == wr_word));                                   // R8

endmodule

// File: tb/mem_lane_steer_tb.sv
module mem_lane_steer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_byte, addr_lsb;
    logic [15:0] wr_word, mem_rdata;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata, rd_word;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    mem_lane_steer u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_byte(req_byte), .addr_lsb(addr_lsb), .wr_word(wr_word),
        .mem_rdata(mem_rdata), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .rd_word(rd_word)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 16'h1357) ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] steer_exp(input logic lsb, input logic [15:0] m);
        return lsb ? {m[15:8], m[15:8]} : m;
    endfunction

    task automatic idle();
        req_valid = 1'b0; req_write = 1'b0; req_byte = 1'b0; addr_lsb = 1'b0;
    endtask

    // read request at negedge, data returns after next posedge
    task automatic do_read(input logic bsz, input logic lsb, input logic [15:0] m, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_byte = bsz; addr_lsb = lsb;
        @(negedge clk);
        idle();
        mem_rdata = m;
        #1;
        chk(tag, rd_word, steer_exp(lsb, m));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; idle(); wr_word = '0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state passes read data straight through
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            mem_rdata = pat(i);
            #1;
            chk("R1 reset passthrough", rd_word, pat(i));
            chk("R7 idle be", {14'd0, mem_be}, 16'd0);
        end

        // R2/R3: reads, every size and lane, many words
        for (int i = 0; i < 64; i++) begin
            for (int c = 0; c < 4; c++) begin
                logic bsz, lsb;
                bsz = c[1]; lsb = c[0];
                do_read(bsz, lsb, pat(i + c), lsb ? "R3 odd read" : "R2 even read");
            end
        end

        // R5/R6/R7/R8: writes and idle, all control combinations
        for (int i = 0; i < 64; i++) begin
            for (int c = 0; c < 16; c++) begin
                logic [1:0] exp_be;
                @(negedge clk);
                req_valid = c[3]; req_write = c[2]; req_byte = c[1]; addr_lsb = c[0];
                wr_word = pat(i) ^ 16'(c);
                #1;
                if (!(c[3] && c[2]))  exp_be = 2'b00;
                else if (!c[1])       exp_be = 2'b11;
                else                  exp_be = c[0] ? 2'b10 : 2'b01;
                chk((!(c[3] && c[2])) ? "R7 no write be" : (c[1] ? "R5 byte be" : "R6 word be"),
                    {14'd0, mem_be}, {14'd0, exp_be});
                chk("R8 wdata", mem_wdata, pat(i) ^ 16'(c));
            end
            @(negedge clk);
            idle();
        end

        // R4: lane held across writes and idles
        for (int i = 0; i < 16; i++) begin
            logic lsb;
            lsb = i[0];
            do_read(1'b1, lsb, pat(i), "R4 setup read");
            for (int c = 0; c < 4; c++) begin
                @(negedge clk);
                req_valid = c[0]; req_write = 1'b1; req_byte = c[1]; addr_lsb = ~lsb;
                mem_rdata = pat(i + 7 + c);
                #1;
                chk("R4 hold during write", rd_word, steer_exp(lsb, pat(i + 7 + c)));
                @(negedge clk);
                idle();
                #1;
                chk("R4 hold after write", rd_word, steer_exp(lsb, pat(i + 7 + c)));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule